// File: doc/BRIEF.md
# Serial Host Register Port

This block is the configuration port of an eight-channel line interface controller. A host reaches it over a three-wire serial link framed by an active-low chip select, with a fourth line carrying read data back. Every complete frame becomes one register access. The port holds a global control register, two fixed identity registers, and a block of four registers for each channel.

Each channel reports three alarm levels: loss of signal, alarm indication, and driver monitor. A change in any alarm level sets a sticky status bit. Reading the status register clears it. The sticky bits, masked by per-channel enables and gated by a global enable, are combined into one active-low interrupt output. Writing to a channel's control register can also fire a one-cycle soft-reset pulse to that channel.

The serial pins are sampled by the system clock, which must run at least eight times faster than the serial clock. A frame is 16 bits long, MSB first: a read/write flag (1 = read), a 7-bit address, then 8 data bits. The host shifts SDI in on rising SCLK edges. The port changes SDO only on falling SCLK edges.

Top module: `serial_host_port`

## Requirements
- R1: Address 0x00 is a read/write global register that keeps all 8 written bits. Bit 7 of it is the global interrupt enable.
- R2: Address 0x01 returns the revision value and address 0x02 returns the device value. Both come from parameters, and writes to these addresses leave them unchanged.
- R3: Channel n owns addresses 4*(n+1) to 4*(n+1)+3. Offset 0 holds the interrupt enables (bit 0 loss of signal, bit 1 alarm indication, bit 2 driver monitor). Offset 1 is the control register. Each channel stores its values independently of the others.
- R4: A read frame returns the register selected in its address phase on SDO, MSB first, during its 8 data bits. SDO changes only on falling SCLK edges and is 0 outside a read data phase.
- R5: A frame in which chip select rises before 16 SCLK rising edges is discarded. It writes nothing and clears no status.
- R6: The status register at offset 2 sets bit 0, 1 or 2 when the loss-of-signal, alarm-indication or driver-monitor level changes in either direction. The bit stays set until it is read.
- R7: A complete read of offset 2 clears only the bits it returned. A change that arrives after the address phase of that read stays set.
- R8: Offset 3 returns the live alarm levels (bit 0 loss of signal, bit 1 alarm indication, bit 2 driver monitor), whatever the enables are set to.
- R9: irqN is 0 only when global bit 7 is 1 and some channel has a status bit set whose enable bit is also 1. Otherwise irqN is 1.
- R10: Writing a 1 to bit 6 of a channel's control register drives that channel's chanRst bit high for exactly one clock. Bit 6 always reads 0, and the other bits are stored.
- R11: Addresses that are not mapped read as 0 and ignore writes.
- R12: After reset, every register reads 0, irqN is 1, SDO is 0 and no chanRst bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| irqN | output | 1 | Active-low combined interrupt |
| losIn | input | NUM_CH | Loss-of-signal level per channel |
| aisIn | input | NUM_CH | Alarm-indication level per channel |
| dmoIn | input | NUM_CH | Driver-monitor level per channel |
| chanRst | output | NUM_CH | One-clock soft-reset pulse per channel |

## Verification
A bit counter that drifts shifts every field of a frame. The error then shows up as wrong read-back data, or as a write that lands at the wrong address, within the same frame. A status latch that loses or keeps a bit it should not shows up at the next status read, and on irqN a few clocks after the alarm edge. Wrong capture timing is exposed by a read that has an alarm edge injected mid-frame: the value returned and the value left behind differ in one bit. The interrupt and reset pulses are compared at the ports after every alarm change and every control write.

// File: rtl/shost_pkg.sv
package shost_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int HDR_W    = 1 + ADDR_W;
  localparam int FRAME_W  = HDR_W + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int CHSEL_W  = ADDR_W - 2;

  localparam int ALM_W    = 3;
  localparam int ALM_LOS  = 0;
  localparam int ALM_AIS  = 1;
  localparam int ALM_DMO  = 2;

  localparam int GIE_BIT  = 7;
  localparam int SRST_BIT = 6;

  localparam logic [ADDR_W-1:0] ADR_GLOBAL = 7'h00;
  localparam logic [ADDR_W-1:0] ADR_REV    = 7'h01;
  localparam logic [ADDR_W-1:0] ADR_DEV    = 7'h02;

  localparam logic [1:0] OFF_IE   = 2'd0;
  localparam logic [1:0] OFF_CTRL = 2'd1;
  localparam logic [1:0] OFF_ISR  = 2'd2;
  localparam logic [1:0] OFF_LVL  = 2'd3;

  typedef struct packed {
    logic              wr;
    logic              cap;
    logic              clr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } hostStb_t;
endpackage

// File: rtl/shost_frame_ctrl.sv
module shost_frame_ctrl
  import shost_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rdData,
  output logic              sdo,
  output hostStb_t          stb
);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_W);

  logic [2:0] sclkSy;
  logic [1:0] csSy;
  logic [1:0] sdiSy;
  logic       sclkRise, sclkFall, active, bitIn;

  logic [CNT_W-1:0]   bitCnt;
  logic [FRAME_W-2:0] shiftIn;
  logic               isRead;
  logic [DATA_W-1:0]  sdoShift;
  logic               sdoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSy <= '0;
      csSy   <= '1;
      sdiSy  <= '0;
    end else begin
      sclkSy <= {sclkSy[1:0], sclk};
      csSy   <= {csSy[0], csN};
      sdiSy  <= {sdiSy[0], sdi};
    end
  end

  assign sclkRise = sclkSy[1] & ~sclkSy[2];
  assign sclkFall = ~sclkSy[1] & sclkSy[2];
  assign active   = ~csSy[1];
  assign bitIn    = sdiSy[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftIn  <= '0;
      isRead   <= 1'b0;
      sdoShift <= '0;
      sdoQ     <= 1'b0;
      stb      <= '0;
    end else begin
      stb.wr  <= 1'b0;
      stb.cap <= 1'b0;
      stb.clr <= 1'b0;
      if (!active) begin
        bitCnt <= '0;
        isRead <= 1'b0;
        sdoQ   <= 1'b0;
      end else begin
        if (sclkRise && bitCnt < CNT_FULL) begin
          shiftIn <= {shiftIn[FRAME_W-3:0], bitIn};
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == CNT_HDR_LAST) begin
            isRead   <= shiftIn[ADDR_W-1];
            stb.cap  <= shiftIn[ADDR_W-1];
            stb.addr <= {shiftIn[ADDR_W-2:0], bitIn};
          end
          if (bitCnt == CNT_LAST) begin
            stb.wr    <= ~isRead;
            stb.clr   <= isRead;
            stb.wdata <= {shiftIn[DATA_W-2:0], bitIn};
          end
        end
        if (stb.cap) begin
          sdoShift <= rdData;
        end else if (sclkFall && isRead && bitCnt >= CNT_HDR && bitCnt < CNT_FULL) begin
          sdoQ     <= sdoShift[DATA_W-1];
          sdoShift <= {sdoShift[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo = sdoQ;

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wr, stb.cap, stb.clr}));

  p_commit_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wr || stb.clr) |-> (bitCnt == CNT_FULL));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    csSy[1] |=> !sdoQ);

  p_sdo_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && !sclkFall) |=> $stable(sdoQ));
endmodule

// File: rtl/shost_regs.sv
module shost_regs
  import shost_pkg::*;
#(
  parameter int                NUM_CH = 8,
  parameter logic [DATA_W-1:0] REV_ID = 8'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStb_t          stb,
  input  logic [NUM_CH-1:0] losIn,
  input  logic [NUM_CH-1:0] aisIn,
  input  logic [NUM_CH-1:0] dmoIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN,
  output logic [NUM_CH-1:0] chanRst
);
  localparam int PAD_W = DATA_W - ALM_W;

  logic [DATA_W-1:0] globReg;
  logic [DATA_W-1:0] chRd [NUM_CH];
  logic [NUM_CH-1:0] chIrq;
  logic              irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globReg <= '0;
    end else if (stb.wr && stb.addr == ADR_GLOBAL) begin
      globReg <= stb.wdata;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [ALM_W-1:0]  almS1, almS2, almPrev, almChg;
    logic [ALM_W-1:0]  isr, capMask;
    logic [DATA_W-1:0] ieReg, ctrlReg;
    logic              rstQ;
    logic              chHit, wrIe, wrCtrl, capHit, clrHit;

    assign chHit  = stb.addr[ADDR_W-1:2] == CHSEL_W'(n + 1);
    assign wrIe   = stb.wr  && chHit && stb.addr[1:0] == OFF_IE;
    assign wrCtrl = stb.wr  && chHit && stb.addr[1:0] == OFF_CTRL;
    assign capHit = stb.cap && chHit && stb.addr[1:0] == OFF_ISR;
    assign clrHit = stb.clr && chHit && stb.addr[1:0] == OFF_ISR;
    assign almChg = almS2 ^ almPrev;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        almS1   <= '0;
        almS2   <= '0;
        almPrev <= '0;
      end else begin
        almS1[ALM_LOS] <= losIn[n];
        almS1[ALM_AIS] <= aisIn[n];
        almS1[ALM_DMO] <= dmoIn[n];
        almS2          <= almS1;
        almPrev        <= almS2;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ieReg   <= '0;
        ctrlReg <= '0;
        rstQ    <= 1'b0;
        isr     <= '0;
        capMask <= '0;
      end else begin
        if (wrIe) ieReg <= stb.wdata;
        rstQ <= wrCtrl && stb.wdata[SRST_BIT];
        if (wrCtrl) begin
          ctrlReg           <= stb.wdata;
          ctrlReg[SRST_BIT] <= 1'b0;
        end
        if (capHit) capMask <= isr;
        isr <= (clrHit ? (isr & ~capMask) : isr) | almChg;
      end
    end

    always_comb begin
      case (stb.addr[1:0])
        OFF_IE:   chRd[n] = ieReg;
        OFF_CTRL: chRd[n] = ctrlReg;
        OFF_ISR:  chRd[n] = {{PAD_W{1'b0}}, isr};
        default:  chRd[n] = {{PAD_W{1'b0}}, almS2};
      endcase
    end

    assign chIrq[n]   = |(isr & ieReg[ALM_W-1:0]);
    assign chanRst[n] = rstQ;

    p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
      rstQ |=> !rstQ);

    p_isr_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      !clrHit |=> ((isr & $past(isr)) == $past(isr)));
  end

  always_comb begin
    rdData = '0;
    if (stb.addr == ADR_GLOBAL)   rdData = globReg;
    else if (stb.addr == ADR_REV) rdData = REV_ID;
    else if (stb.addr == ADR_DEV) rdData = DEV_ID;
    else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (stb.addr[ADDR_W-1:2] == CHSEL_W'(n + 1)) rdData = chRd[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= globReg[GIE_BIT] & (|chIrq);
  end

  assign irqN = ~irqQ;

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !globReg[GIE_BIT] |=> irqN);

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chIrq == '0) |=> irqN);
endmodule

// File: rtl/serial_host_port.sv
module serial_host_port
  import shost_pkg::*;
#(
  parameter int                NUM_CH = 8,
  parameter logic [DATA_W-1:0] REV_ID = 8'h01,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              irqN,
  input  logic [NUM_CH-1:0] losIn,
  input  logic [NUM_CH-1:0] aisIn,
  input  logic [NUM_CH-1:0] dmoIn,
  output logic [NUM_CH-1:0] chanRst
);
  hostStb_t          stb;
  logic [DATA_W-1:0] rdData;

  shost_frame_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .sdi    (sdi),
    .rdData (rdData),
    .sdo    (sdo),
    .stb    (stb)
  );

  shost_regs #(
    .NUM_CH (NUM_CH),
    .REV_ID (REV_ID),
    .DEV_ID (DEV_ID)
  ) i_regs (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .losIn   (losIn),
    .aisIn   (aisIn),
    .dmoIn   (dmoIn),
    .rdData  (rdData),
    .irqN    (irqN),
    .chanRst (chanRst)
  );
endmodule

// File: tb/test_serial_host_port.sv
module test_serial_host_port;
  localparam int NCH = 8;
  localparam logic [7:0] REV = 8'h01;
  localparam logic [7:0] DEV = 8'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [NCH-1:0] losIn = '0;
  logic [NCH-1:0] aisIn = '0;
  logic [NCH-1:0] dmoIn = '0;
  logic sdo, irqN;
  logic [NCH-1:0] chanRst;

  int nCmp = 0;
  int nBad = 0;
  int rstCnt [NCH];
  int toggleAt = -1;
  int toggleCh = 0;
  logic [7:0] expVal [$];
  string      expTag [$];

  serial_host_port #(.NUM_CH(NCH), .REV_ID(REV), .DEV_ID(DEV)) i_serial_host_port (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .irqN(irqN), .losIn(losIn), .aisIn(aisIn), .dmoIn(dmoIn), .chanRst(chanRst)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rstN) begin
      for (int n = 0; n < NCH; n++) if (chanRst[n]) rstCnt[n]++;
    end
  end

  task automatic sendFrame(input bit rd, input logic [6:0] a, input logic [7:0] d, input int nbits);
    logic [15:0] f;
    f = {rd, a, d};
    @(negedge clk) csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = f[15-i];
      if (i == toggleAt) aisIn[toggleCh] = ~aisIn[toggleCh];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic writeReg(input logic [6:0] a, input logic [7:0] d);
    sendFrame(1'b0, a, d, 16);
  endtask

  task automatic readExp(input logic [6:0] a, input logic [7:0] e, input string tag);
    expVal.push_back(e);
    expTag.push_back(tag);
    sendFrame(1'b1, a, 8'h00, 16);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  // monitor: rebuilds read data from SDO and compares against the queue
  initial begin
    forever begin
      int cnt;
      bit rd;
      logic [7:0] got;
      logic a, b;
      @(negedge csN);
      cnt = 0; rd = 0; got = '0;
      while (csN == 1'b0) begin
        @(posedge sclk or posedge csN);
        if (csN) break;
        if (cnt == 0) rd = sdi;
        if (rd && cnt >= 8) begin
          a = sdo;
          repeat (6) @(negedge clk);
          b = sdo;
          check(a === b, "R4 sdo stable while sclk high", int'(b), int'(a));
          got = {got[6:0], a};
        end
        cnt++;
      end
      if (rd && cnt >= 16) begin
        if (expVal.size() == 0) begin
          check(1'b0, "R4 unexpected read", int'(got), 0);
        end else begin
          logic [7:0] e;
          string t;
          e = expVal.pop_front();
          t = expTag.pop_front();
          check(got === e, t, int'(got), int'(e));
        end
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    for (int n = 0; n < NCH; n++) rstCnt[n] = 0;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    check(irqN === 1'b1, "R12 irqN after reset", int'(irqN), 1);
    check(sdo === 1'b0, "R12 sdo after reset", int'(sdo), 0);
    check(chanRst === '0, "R12 chanRst after reset", int'(chanRst), 0);
    readExp(7'h00, 8'h00, "R12 global reset value");
    readExp(7'd5, 8'h00, "R12 channel ctrl reset value");

    writeReg(7'h00, 8'hA5);
    readExp(7'h00, 8'hA5, "R1 global readback");

    readExp(7'h01, REV, "R2 revision");
    readExp(7'h02, DEV, "R2 device");
    writeReg(7'h01, 8'hFF);
    readExp(7'h01, REV, "R2 revision write ignored");

    writeReg(7'd4, 8'h38);
    writeReg(7'd32, 8'h58);
    writeReg(7'd33, 8'h0F);
    readExp(7'd4, 8'h38, "R3 ch0 enables");
    readExp(7'd32, 8'h58, "R3 ch7 enables");
    readExp(7'd8, 8'h00, "R3 ch1 untouched");
    readExp(7'd33, 8'h0F, "R3 ch7 control");

    for (int n = 0; n < NCH; n++) rstCnt[n] = 0;
    writeReg(7'd17, 8'h41);
    check(rstCnt[3] == 1, "R10 ch3 pulse length", rstCnt[3], 1);
    begin
      int others;
      others = 0;
      for (int n = 0; n < NCH; n++) if (n != 3) others += rstCnt[n];
      check(others == 0, "R10 other channels quiet", others, 0);
    end
    readExp(7'd17, 8'h01, "R10 reset bit reads 0");

    writeReg(7'd48, 8'h77);
    readExp(7'd48, 8'h00, "R11 unmapped high");
    readExp(7'd3, 8'h00, "R11 unmapped low");

    losIn[2] = 1'b1; settle();
    readExp(7'd15, 8'h01, "R8 live level");
    readExp(7'd14, 8'h01, "R6 rise latched");
    readExp(7'd14, 8'h00, "R7 cleared after read");
    losIn[2] = 1'b0; settle();
    readExp(7'd14, 8'h01, "R6 fall latched");
    readExp(7'd15, 8'h00, "R8 live level low");

    dmoIn[4] = 1'b1; settle();
    sendFrame(1'b1, 7'd22, 8'h00, 12);
    readExp(7'd22, 8'h04, "R5 truncated read kept status");
    sendFrame(1'b0, 7'h00, 8'h00, 12);
    readExp(7'h00, 8'hA5, "R5 truncated write dropped");

    losIn[5] = 1'b1; settle();
    toggleCh = 5; toggleAt = 11;
    readExp(7'd26, 8'h01, "R7 value at capture");
    toggleAt = -1; settle();
    readExp(7'd26, 8'h02, "R7 late change kept");
    readExp(7'd26, 8'h00, "R7 all cleared");

    check(irqN === 1'b1, "R9 idle before enable", int'(irqN), 1);
    writeReg(7'd28, 8'h02);
    dmoIn[6] = 1'b1; settle();
    check(irqN === 1'b1, "R9 masked source", int'(irqN), 1);
    aisIn[6] = 1'b1; settle();
    check(irqN === 1'b0, "R9 enabled source", int'(irqN), 0);
    readExp(7'd31, 8'h06, "R8 level with enables set");
    writeReg(7'h00, 8'h25); settle();
    check(irqN === 1'b1, "R9 global gate off", int'(irqN), 1);
    writeReg(7'h00, 8'hA5); settle();
    check(irqN === 1'b0, "R9 global gate on", int'(irqN), 0);
    readExp(7'd30, 8'h06, "R6 two changes latched");
    settle();
    check(irqN === 1'b1, "R9 released after read", int'(irqN), 1);
    check(sdo === 1'b0, "R4 sdo idle", int'(sdo), 0);

    while (expVal.size() != 0) @(negedge clk);
    finishRun();
  end
endmodule